// File: doc/BRIEF.md
# Serial ADC Command and Readout Interface

This block is the device-side digital logic of an eight-channel serial successive-approximation converter. A host drives chip select, a serial clock that idles low, and a data line. The block looks for a start bit, collects an 8-bit command, and decodes four fields from it: which channel, unipolar or bipolar, single-ended or differential, and the clock/power mode. These fields go out on registered ports for the analog side. When the command asks for the external-clock mode, the block raises a strobe for one serial-clock period and then shifts a 12-bit result out on the following falling edges.

All inputs are synchronised to the system clock `clk` and the serial-clock edges are found by oversampling. The analog stand-in supplies the conversion value as a parallel word in offset-binary form. The block captures this word when the command completes and applies the output coding that the polarity field selects. Two enable outputs tell the pad ring when the data and strobe pins are driven.

Top module: `adc_serial_if`

## Requirements
- R1: While chip select is low, every rising serial-clock edge samples the data line. Zeros sampled before the first 1 are discarded. The first 1 becomes bit 7 of the command, and the next seven rising edges supply bits 6 down to 0.
- R2: When the eighth command bit arrives, the field outputs take these values from the command: `chan_o` = bits 6:4, `unipolar_o` = bit 3, `single_o` = bit 2, `mode_o` = bits 1:0. The outputs hold their value until the next complete command.
- R3: Mode 2'b11 is external clock, and it alone raises the strobe. The strobe goes high at the first falling edge after the command and low at the next falling edge. Modes 2'b00 (full power-down), 2'b01 (fast power-down) and 2'b10 (internal clock) produce no strobe, leave data-out at 0, and re-arm the start-bit search at once.
- R4: In external-clock mode the 12 result bits appear on `dout`, MSB first, on the 2nd through 13th falling edges after the command.
- R5: With `unipolar_o`=1 the result equals the sample word (straight binary). With `unipolar_o`=0 the result is the sample word with its MSB inverted (two's complement).
- R6: The sample word is captured when the command completes. Later changes on `sample_i` do not alter the result being shifted.
- R7: From the command's completion until data-out returns to 0 after the last result bit, rising edges carrying 1s start no command. Data-out then stays 0 until chip select rises, and a new command is accepted in the same chip-select window.
- R8: While chip select is high, `dout_oe` and `strobe_oe` are 0, `dout` and `strobe` are 0, and any command or conversion in progress is abandoned. After chip select falls, `strobe_oe` rises with `strobe` at 0.
- R9: After reset all outputs are 0: the enables, data, strobe and every decoded field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host, idles low |
| din | input | 1 | Serial command data |
| sample_i | input | RES_W | Conversion value from the analog stand-in, offset binary |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for the data pin |
| strobe | output | 1 | Conversion strobe |
| strobe_oe | output | 1 | Drive enable for the strobe pin |
| chan_o | output | 3 | Decoded channel select |
| unipolar_o | output | 1 | 1 = unipolar, 0 = bipolar |
| single_o | output | 1 | 1 = single-ended, 0 = differential |
| mode_o | output | 2 | Decoded clock/power mode |

## Verification
The hardest case to reach is 1s arriving on the data line while a result is still shifting out. These must not start a command, and the search must re-arm at the right falling edge so that a command sent straight afterwards in the same chip-select window is decoded. The sweep reaches this by sending 0xFF and then 0xF0 as the readout bytes of selected external-clock conversions, followed at once by a second command. Chip select is also raised partway through a result and partway through a command, to show that both are abandoned and the next conversion starts clean.

// File: rtl/adc_if_pkg.sv
// Package: shared constants and types for the serial ADC interface.
// Assumes an 8-bit command whose field positions are fixed by the host protocol.
package adc_if_pkg;

    localparam int CMD_BITS  = 8;
    localparam int CHAN_BITS = 3;
    localparam int CHAN_LSB  = 4;
    localparam int UNI_POS   = 3;
    localparam int SGL_POS   = 2;

    typedef enum logic [1:0] {
        MODE_FULL_PD = 2'b00,
        MODE_FAST_PD = 2'b01,
        MODE_INT_CLK = 2'b10,
        MODE_EXT_CLK = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic [CHAN_BITS-1:0] chan;
        logic                 unipolar;
        logic                 single;
        pwr_mode_e            mode;
    } cmd_fields_t;

    typedef enum logic [1:0] {
        RX_HUNT    = 2'd0,
        RX_COLLECT = 2'd1,
        RX_WAIT    = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_PEND   = 2'd1,
        TX_STROBE = 2'd2,
        TX_SHIFT  = 2'd3
    } tx_state_e;

    // Splits a complete command byte into its fields.
    function automatic cmd_fields_t decode_cmd(input logic [CMD_BITS-1:0] b);
        cmd_fields_t f;
        f.chan     = b[CHAN_LSB +: CHAN_BITS];
        f.unipolar = b[UNI_POS];
        f.single   = b[SGL_POS];
        f.mode     = pwr_mode_e'(b[1:0]);
        return f;
    endfunction

endpackage

// File: rtl/adc_in_sync.sv
// Module: input synchroniser for one pin.
// STAGES flip-flops in series; with STAGES = 0 the pin passes straight
// through, for callers whose inputs are already in the clk domain.
// Assumes the reset value matches the pin's idle level.
module adc_in_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [STAGES-1:0] ff;

            // Shift the pin through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ff <= {STAGES{RST_VAL}};
                end else begin
                    ff[0] <= d_i;
                    for (int i = 1; i < STAGES; i++) begin
                        ff[i] <= ff[i-1];
                    end
                end
            end

            assign q_o = ff[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/adc_sclk_edges.sv
// Module: serial-clock edge finder.
// Compares the synchronised serial clock with its value one clk earlier and
// gives single-cycle rise and fall pulses. Assumes sclk is much slower than clk.
module adc_sclk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic rise_o,
    output logic fall_o
);

    logic sclk_q;

    // Remember the previous serial-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_i;
    end

    assign rise_o = sclk_i & ~sclk_q;
    assign fall_o = ~sclk_i & sclk_q;

endmodule

// File: rtl/adc_cmd_rx.sv
// Module: command receiver.
// Hunts for the start bit, shifts in the rest of the command and registers
// the decoded fields. After an external-clock command it waits for the
// transmitter to release it before hunting again.
// Assumes cs_n_i, rise_i and din_i are in the clk domain.
module adc_cmd_rx
    import adc_if_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n_i,
    input  logic        rise_i,
    input  logic        din_i,
    input  logic        release_i,
    output cmd_fields_t fields_o,
    output logic        done_o
);

    localparam int CNT_W = $clog2(CMD_BITS + 1);

    rx_state_e             state;
    logic [CMD_BITS-2:0]   shreg;
    logic [CNT_W-1:0]      cnt;
    logic [CMD_BITS-1:0]   byte_next;
    cmd_fields_t           fields_q;

    assign byte_next = {shreg, din_i};

    // Framing, shifting and field capture for one command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_HUNT;
            shreg    <= '0;
            cnt      <= '0;
            done_o   <= 1'b0;
            fields_q <= '0;
        end else begin
            done_o <= 1'b0;
            if (cs_n_i) begin
                state <= RX_HUNT;
                cnt   <= '0;
            end else begin
                case (state)
                    RX_HUNT: begin
                        if (rise_i && din_i) begin
                            shreg <= {{(CMD_BITS-2){1'b0}}, 1'b1};
                            cnt   <= CNT_W'(1);
                            state <= RX_COLLECT;
                        end
                    end
                    RX_COLLECT: begin
                        if (rise_i) begin
                            shreg <= byte_next[CMD_BITS-2:0];
                            if (cnt == CNT_W'(CMD_BITS - 1)) begin
                                cnt      <= '0;
                                done_o   <= 1'b1;
                                fields_q <= decode_cmd(byte_next);
                                state    <= (pwr_mode_e'(byte_next[1:0]) == MODE_EXT_CLK)
                                            ? RX_WAIT : RX_HUNT;
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    RX_WAIT: begin
                        if (release_i) state <= RX_HUNT;
                    end
                    default: state <= RX_HUNT;
                endcase
            end
        end
    end

    assign fields_o = fields_q;

    // R1: a zero seen while hunting keeps the receiver hunting.
    a_r1_zero_keeps_hunting: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HUNT && !cs_n_i && rise_i && !din_i) |=> state == RX_HUNT);

    // R2: the decoded fields change only on the clock that completes a command.
    a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fields_q != $past(fields_q)) |-> done_o);

    // R7: while waiting on the transmitter no command can complete.
    a_r7_wait_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_WAIT && !release_i && !cs_n_i) |=> !done_o);

endmodule

// File: rtl/adc_result_tx.sv
// Module: result transmitter.
// Captures the coded sample on load, then steps through strobe and data
// on successive serial-clock falling edges and releases the receiver.
// Assumes fall_i and cs_n_i are in the clk domain.
module adc_result_tx #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             fall_i,
    input  logic             load_i,
    input  logic             unipolar_i,
    input  logic [RES_W-1:0] sample_i,
    output logic             dout_o,
    output logic             strobe_o,
    output logic             release_o
);

    import adc_if_pkg::*;

    localparam int               CNT_W    = $clog2(RES_W + 1);
    localparam logic [RES_W-1:0] MSB_FLIP = {1'b1, {(RES_W-1){1'b0}}};

    tx_state_e        state;
    logic [RES_W-1:0] sh;
    logic [RES_W-1:0] code;
    logic [CNT_W-1:0] cnt;

    // Output coding: offset binary passes through, bipolar flips the MSB.
    always_comb begin
        code = unipolar_i ? sample_i : (sample_i ^ MSB_FLIP);
    end

    // Strobe and result sequencing on serial-clock falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TX_IDLE;
            sh        <= '0;
            cnt       <= '0;
            dout_o    <= 1'b0;
            strobe_o  <= 1'b0;
            release_o <= 1'b0;
        end else begin
            release_o <= 1'b0;
            if (cs_n_i) begin
                state    <= TX_IDLE;
                cnt      <= '0;
                dout_o   <= 1'b0;
                strobe_o <= 1'b0;
            end else begin
                case (state)
                    TX_IDLE: begin
                        if (load_i) begin
                            sh    <= code;
                            state <= TX_PEND;
                        end
                    end
                    TX_PEND: begin
                        if (fall_i) begin
                            strobe_o <= 1'b1;
                            state    <= TX_STROBE;
                        end
                    end
                    TX_STROBE: begin
                        if (fall_i) begin
                            strobe_o <= 1'b0;
                            dout_o   <= sh[RES_W-1];
                            sh       <= sh << 1;
                            cnt      <= CNT_W'(1);
                            state    <= TX_SHIFT;
                        end
                    end
                    TX_SHIFT: begin
                        if (fall_i) begin
                            if (cnt == CNT_W'(RES_W)) begin
                                dout_o    <= 1'b0;
                                cnt       <= '0;
                                release_o <= 1'b1;
                                state     <= TX_IDLE;
                            end else begin
                                dout_o <= sh[RES_W-1];
                                sh     <= sh << 1;
                                cnt    <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    default: state <= TX_IDLE;
                endcase
            end
        end
    end

    // R3: the strobe lasts until the next falling serial-clock edge only.
    a_r3_strobe_one_period: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && fall_i && !cs_n_i) |=> !strobe_o);

    // R3: data-out is quiet while the strobe is high.
    a_r3_strobe_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> !dout_o);

    // R4: the receiver is released only after a full result.
    a_r4_release_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> (!strobe_o && !dout_o));

endmodule

// File: rtl/adc_serial_if.sv
// Module: top of the serial ADC command and readout interface.
// Synchronises the host pins, finds serial-clock edges, receives commands,
// sends results and drives the pad enables.
// Assumes sclk idles low and runs well below clk / (2 * (SYNC_STAGES + 2)).
module adc_serial_if #(
    parameter int RES_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [RES_W-1:0] sample_i,
    output logic             dout,
    output logic             dout_oe,
    output logic             strobe,
    output logic             strobe_oe,
    output logic [2:0]       chan_o,
    output logic             unipolar_o,
    output logic             single_o,
    output logic [1:0]       mode_o
);

    import adc_if_pkg::*;

    logic        cs_s, sclk_s, din_s;
    logic        rise, fall;
    logic        cmd_done, tx_release, tx_load;
    logic        oe_q;
    cmd_fields_t fields;

    adc_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d_i(cs_n), .q_o(cs_s));
    adc_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d_i(sclk), .q_o(sclk_s));
    adc_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .d_i(din), .q_o(din_s));

    adc_sclk_edges u_edges (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_s), .rise_o(rise), .fall_o(fall));

    adc_cmd_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (cs_s),
        .rise_i    (rise),
        .din_i     (din_s),
        .release_i (tx_release),
        .fields_o  (fields),
        .done_o    (cmd_done)
    );

    assign tx_load = cmd_done && (fields.mode == MODE_EXT_CLK);

    adc_result_tx #(.RES_W(RES_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_s),
        .fall_i     (fall),
        .load_i     (tx_load),
        .unipolar_i (fields.unipolar),
        .sample_i   (sample_i),
        .dout_o     (dout),
        .strobe_o   (strobe),
        .release_o  (tx_release)
    );

    // Pad drive enables follow the synchronised chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= ~cs_s;
    end

    assign dout_oe    = oe_q;
    assign strobe_oe  = oe_q;
    assign chan_o     = fields.chan;
    assign unipolar_o = fields.unipolar;
    assign single_o   = fields.single;
    assign mode_o     = fields.mode;

    // R8: chip select high silences data and strobe on the next clock.
    a_r8_cs_high_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (!strobe && !dout));

    // R8: the strobe is never high on an undriven pin.
    a_r8_strobe_driven: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> strobe_oe);

    // R3: only an external-clock command produces a strobe.
    a_r3_strobe_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (mode_o == 2'b11));

endmodule

// File: tb/tb_adc_serial_if.sv
`timescale 1ns/1ps
module tb_adc_serial_if;

    logic        clk = 1'b0;
    logic        rst_n, cs_n, sclk, din;
    logic [11:0] sample;
    logic        dout, dout_oe, strobe, strobe_oe;
    logic [2:0]  chan_o;
    logic        unipolar_o, single_o;
    logic [1:0]  mode_o;

    int vectors = 0;
    int fails   = 0;
    bit ended   = 0;

    always #4 clk = ~clk;

    adc_serial_if dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .sample_i(sample), .dout(dout), .dout_oe(dout_oe), .strobe(strobe),
        .strobe_oe(strobe_oe), .chan_o(chan_o), .unipolar_o(unipolar_o),
        .single_o(single_o), .mode_o(mode_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // One serial-clock period; returns dout and strobe seen after its fall.
    task automatic sbit(input logic b, output logic d, output logic s);
        din = b;
        tick(3);
        sclk = 1'b1;
        tick(5);
        sclk = 1'b0;
        tick(5);
        d = dout;
        s = strobe;
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rd, output logic [7:0] rs);
        for (int i = 7; i >= 0; i--) sbit(tx[i], rd[i], rs[i]);
    endtask

    function automatic logic [6:0] fields();
        return {chan_o, unipolar_o, single_o, mode_o};
    endfunction

    task automatic cs_up();
        cs_n = 1'b1;
        tick(6);
        chk("R8 enables off", {dout_oe, strobe_oe}, 0);
        chk("R8 pins quiet", {dout, strobe}, 0);
    endtask

    // One full conversion, with optional busy-line ones and a follow-up command.
    task automatic conv(input logic [7:0] cmd, input logic [11:0] smp,
                        input int nlead, input bit busy, input logic [7:0] cmd2);
        logic [7:0]  rd1, rs1, rd2, rs2, rd3, rs3, rdx, rsx;
        logic        d, s;
        logic [11:0] code;
        sample = smp;
        cs_n   = 1'b0;
        tick(6);
        chk("R8 strobe_oe after cs fall", strobe_oe, 1);
        chk("R8 strobe low after cs fall", strobe, 0);
        for (int i = 0; i < nlead; i++) sbit(1'b0, d, s);
        xbyte(cmd, rd1, rs1);
        sample = ~smp;
        xbyte(busy ? 8'hFF : 8'h00, rd2, rs2);
        xbyte(busy ? 8'hF0 : 8'h00, rd3, rs3);
        code = cmd[3] ? smp : (smp ^ 12'h800);
        chk("R1 R2 fields", fields(), cmd[6:0]);
        if (cmd[1:0] == 2'b11) begin
            chk("R3 strobe timing", {rs1, rs2, rs3}, 24'h010000);
            chk("R4 R5 R6 result", {rd2, rd3}, {code, 4'h0});
            chk("R1 dout quiet during command", rd1, 0);
        end else begin
            chk("R3 no strobe outside ext mode", {rs1, rs2, rs3}, 0);
            chk("R3 dout idle outside ext mode", {rd1, rd2, rd3}, 0);
        end
        if (busy) begin
            chk("R7 ones during readout ignored", fields(), cmd[6:0]);
            xbyte(cmd2, rdx, rsx);
            chk("R7 rearmed command", fields(), cmd2[6:0]);
            chk("R7 tail stays zero", rdx, 0);
        end
        cs_up();
    endtask

    initial begin
        rst_n  = 1'b0;
        cs_n   = 1'b1;
        sclk   = 1'b0;
        din    = 1'b0;
        sample = '0;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R9 reset state
        chk("R9 reset enables", {dout_oe, strobe_oe}, 0);
        chk("R9 reset pins", {dout, strobe}, 0);
        chk("R9 reset fields", fields(), 0);

        // Sweep every command with varied lead-in and sample words.
        for (int c = 0; c < 128; c++) begin
            logic [7:0] cmd, cmd2;
            bit         busy;
            cmd  = {1'b1, 7'(c)};
            busy = (c[1:0] == 2'b11) && c[5];
            cmd2 = {1'b1, 7'((c * 53 + 9) & 127)};
            conv(cmd, 12'((c * 293 + 77) & 12'hFFF), c % 3, busy, cmd2);
        end

        // Coding corners in both polarities.
        conv(8'hDB, 12'h000, 0, 0, 8'h00);
        conv(8'hDB, 12'hFFF, 0, 0, 8'h00);
        conv(8'hD3, 12'h800, 1, 0, 8'h00);
        conv(8'hD3, 12'h7FF, 1, 0, 8'h00);
        conv(8'hD3, 12'h000, 2, 0, 8'h00);
        conv(8'hD3, 12'hFFF, 2, 0, 8'h00);

        // R8: abort during readout, then a clean conversion.
        begin
            logic [7:0] rd, rs;
            logic       d, s;
            cs_n = 1'b0;
            tick(6);
            xbyte(8'h8F, rd, rs);
            sbit(1'b0, d, s);
            sbit(1'b0, d, s);
            sbit(1'b0, d, s);
            cs_up();
            conv(8'hAF, 12'h5A3, 0, 0, 8'h00);

            // R8: abort mid-command; the partial command must be dropped.
            cs_n = 1'b0;
            tick(6);
            sbit(1'b1, d, s);
            sbit(1'b1, d, s);
            sbit(1'b1, d, s);
            cs_up();
            chk("R8 partial command dropped", fields(), 7'h2F);
            cs_n = 1'b0;
            tick(6);
            xbyte(8'h9A, rd, rs);
            chk("R8 fresh command after abort", fields(), 7'h1A);
            cs_up();
        end

        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            vectors++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule